// File: doc/BRIEF.md
# Length-Steered Serial Register Loader

This block is the serial slave port of a display controller. A host lowers an active-low select, clocks a bit stream in most significant bit first, and raises the select again. The number of serial clocks seen during the selected window alone decides where the bits go. Eight clocks write an 8-bit configuration word and twenty-four clocks write a 24-bit display word. There are no address or steering bits, and any other count is dropped. Nothing visible changes until the select is released, so the host may shift as slowly as it likes.

The serial pins are sampled by the block's own clock, and edges of the serial clock and the select are found by comparing successive samples. A serial output replays the shift register's top bit half a serial period late, which lets several ports be chained. Each release of the select produces a one-cycle blanking strobe. Writing configuration bit 0 as zero wipes the display word. The top bit of the display word is also brought out as a brightness select.

Top module: `len_steer_loader`

## Requirements
- R1: Bits are taken on rising serial-clock edges, most significant bit first, so a word sent MSB first lands unchanged in its register.
- R2: A window of exactly 8 serial clocks writes `cfg_q` with the 8 bits shifted and leaves `disp_q` alone unless R8 applies.
- R3: A window of exactly 24 serial clocks writes `disp_q` with the 24 bits shifted and leaves `cfg_q` unchanged.
- R4: `cfg_q` and `disp_q` change only on the cycle after `sel_n` rises. They hold while bits are being shifted.
- R5: While `sel_n` is high, `sdout` is 0 and serial clock edges shift nothing and count nothing.
- R6: `sdout` changes only after a falling serial-clock edge. After the falling edge that follows the k-th rising edge (counting from 0), it carries bit k-23 of the stream, or 0 when k < 23.
- R7: `blank_o` is high for exactly one cycle after every rising edge of `sel_n`, including windows that are dropped.
- R8: A configuration write whose bit 0 is 0 also clears `disp_q` to zero.
- R9: `bright_o` always equals bit 23 of `disp_q`.
- R10: If `sel_n` changes while `sclk` is high, that window is dropped. Normal operation returns once `sel_n` is high with `sclk` low.
- R11: A window of any count other than 8 or 24 writes nothing. The counter saturates, so a count such as 40 cannot alias to 8.
- R12: After reset, `cfg_q`, `disp_q`, `bright_o`, `blank_o` and `sdout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, already synchronised to `clk` |
| sdin | input | 1 | Serial data in |
| sel_n | input | 1 | Active-low transfer select |
| sdout | output | 1 | Serial data out, half a serial period behind the shifter |
| cfg_q | output | 8 | Configuration word |
| disp_q | output | 24 | Display word |
| blank_o | output | 1 | One-cycle blanking strobe on select release |
| bright_o | output | 1 | Brightness select, top bit of the display word |

## Verification
Four rules are checked on every cycle: both registers hold except right after a select release, `sdout` stays low while idle, `sdout` moves only after a falling serial-clock edge, and the blanking strobe matches select releases one for one. Steering by bit count can only be shown by the bench's scenarios. These cover every configuration value, the full sweep of dropped lengths including saturation, the 24½-stage serial output, the clearing effect of bit 0, and the two ways of losing synchronisation and getting it back.

// File: rtl/loader_pkg.sv
package loader_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_CFG  = 2'd1,
      TGT_DISP = 2'd2
   } tgt_e;
endpackage

// File: rtl/ld_edge_det.sv
module ld_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic sel_n,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic sel_rise,
   output logic sel_fall,
   output logic in_sync
);
   logic sclk_d, sel_d, desync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         sel_d  <= 1'b1;
      end else begin
         sclk_d <= sclk;
         sel_d  <= sel_n;
      end
   end

   assign sclk_rise = sclk & ~sclk_d;
   assign sclk_fall = ~sclk & sclk_d;
   assign sel_rise  = sel_n & ~sel_d;
   assign sel_fall  = ~sel_n & sel_d;

   // select edge with serial clock high loses sync; idle-low clock restores it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         desync_q <= 1'b0;
      else if ((sel_rise | sel_fall) & sclk)
         desync_q <= 1'b1;
      else if (sel_n & ~sclk)
         desync_q <= 1'b0;
   end

   assign in_sync = ~desync_q;
endmodule

// File: rtl/ld_shifter.sv
module ld_shifter #(
   parameter int SR_W       = 24,
   parameter int CNT_W      = 5,
   parameter bit HALF_STAGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sdin,
   input  logic             sel_n,
   input  logic             shift_en,
   input  logic             sclk_fall,
   output logic [SR_W-1:0]  sr_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             sdout
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (sel_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         sr_q  <= {sr_q[SR_W-2:0], sdin};
         if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   logic dout_q;
   generate
      if (HALF_STAGE) begin : g_half
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          dout_q <= 1'b0;
            else if (sel_n)      dout_q <= 1'b0;
            else if (sclk_fall)  dout_q <= sr_q[SR_W-1];
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          dout_q <= 1'b0;
            else if (sel_n)      dout_q <= 1'b0;
            else if (shift_en)   dout_q <= sr_q[SR_W-2];
         end
      end
   endgenerate

   assign sdout = dout_q;
endmodule

// File: rtl/ld_commit.sv
module ld_commit
   import loader_pkg::*;
#(
   parameter int CFG_W  = 8,
   parameter int DISP_W = 24,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_rise,
   input  logic              commit_ok,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DISP_W-1:0] sr,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [DISP_W-1:0] disp_q,
   output logic              blank_o
);
   localparam logic [CNT_W-1:0] N_CFG  = CNT_W'(CFG_W);
   localparam logic [CNT_W-1:0] N_DISP = CNT_W'(DISP_W);

   tgt_e tgt;
   always_comb begin
      tgt = TGT_NONE;
      if (sel_rise && commit_ok) begin
         if (cnt == N_CFG)       tgt = TGT_CFG;
         else if (cnt == N_DISP) tgt = TGT_DISP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         disp_q  <= '0;
         blank_o <= 1'b0;
      end else begin
         blank_o <= sel_rise;
         case (tgt)
            TGT_CFG: begin
               cfg_q <= sr[CFG_W-1:0];
               if (!sr[0]) disp_q <= '0;
            end
            TGT_DISP: disp_q <= sr;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/len_steer_loader.sv
module len_steer_loader #(
   parameter int CFG_W      = 8,
   parameter int DISP_W     = 24,
   parameter int CNT_W      = 5,
   parameter bit HALF_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sdin,
   input  logic              sel_n,
   output logic              sdout,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [DISP_W-1:0] disp_q,
   output logic              blank_o,
   output logic              bright_o
);
   generate
      if (DISP_W <= CFG_W) begin : g_bad_w
         $error("DISP_W must exceed CFG_W");
      end
      if ((1 << CNT_W) - 1 <= DISP_W) begin : g_bad_cnt
         $error("CNT_W too narrow to saturate above DISP_W");
      end
   endgenerate

   logic sclk_rise, sclk_fall, sel_rise, sel_fall, in_sync;
   logic [DISP_W-1:0] sr;
   logic [CNT_W-1:0]  cnt;

   ld_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .sel_rise(sel_rise), .sel_fall(sel_fall), .in_sync(in_sync)
   );

   ld_shifter #(.SR_W(DISP_W), .CNT_W(CNT_W), .HALF_STAGE(HALF_STAGE)) u_shift (
      .clk(clk), .rst_n(rst_n), .sdin(sdin), .sel_n(sel_n),
      .shift_en(sclk_rise & in_sync & ~sel_fall),
      .sclk_fall(sclk_fall), .sr_q(sr), .cnt_q(cnt), .sdout(sdout)
   );

   ld_commit #(.CFG_W(CFG_W), .DISP_W(DISP_W), .CNT_W(CNT_W)) u_commit (
      .clk(clk), .rst_n(rst_n), .sel_rise(sel_rise),
      .commit_ok(in_sync & ~sclk), .cnt(cnt), .sr(sr),
      .cfg_q(cfg_q), .disp_q(disp_q), .blank_o(blank_o)
   );

   assign bright_o = disp_q[DISP_W-1];
endmodule

// File: rtl/len_steer_loader_chk.sv
module len_steer_loader_chk #(
   parameter int CFG_W  = 8,
   parameter int DISP_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk,
   input logic              sel_n,
   input logic              sdout,
   input logic [CFG_W-1:0]  cfg_q,
   input logic [DISP_W-1:0] disp_q,
   input logic              blank_o
);
   logic sel_prev, sclk_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_prev  <= 1'b1;
         sclk_prev <= 1'b0;
      end else begin
         sel_prev  <= sel_n;
         sclk_prev <= sclk;
      end
   end

   wire rel  = sel_n & ~sel_prev;
   wire fall = sclk_prev & ~sclk;

   p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rel |=> $stable(cfg_q));
   p_disp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rel |=> $stable(disp_q));
   p_dout_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> !sdout);
   p_dout_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !fall) |=> $stable(sdout));
   p_blank_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rel |=> blank_o);
   p_blank_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rel |=> !blank_o);
endmodule

bind len_steer_loader len_steer_loader_chk #(.CFG_W(CFG_W), .DISP_W(DISP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdout(sdout),
   .cfg_q(cfg_q), .disp_q(disp_q), .blank_o(blank_o)
);

// File: tb/len_steer_loader_tb.sv
module len_steer_loader_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, sdin = 1'b0, sel_n = 1'b1;
   logic sdout, blank_o, bright_o;
   logic [7:0]  cfg_q;
   logic [23:0] disp_q;

   int n_tests = 0, n_fail = 0, blank_cnt = 0;
   logic [7:0]  exp_cfg  = '0;
   logic [23:0] exp_disp = '0;

   always #10 clk = ~clk;

   len_steer_loader u_dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .sel_n(sel_n),
      .sdout(sdout), .cfg_q(cfg_q), .disp_q(disp_q),
      .blank_o(blank_o), .bright_o(bright_o)
   );

   always @(negedge clk) if (blank_o) blank_cnt++;

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clk_bit(logic b);
      sdin = b; tick(1);
      sclk = 1'b1; tick(2);
      sclk = 1'b0; tick(2);
   endtask

   task automatic xfer(logic [63:0] bits, int n);
      sel_n = 1'b0; tick(2);
      for (int i = 0; i < n; i++) clk_bit(bits[n-1-i]);
      sel_n = 1'b1; tick(3);
   endtask

   task automatic check_regs(string req);
      chk(cfg_q == exp_cfg, req, "cfg_q", 32'(cfg_q), 32'(exp_cfg));
      chk(disp_q == exp_disp, req, "disp_q", 32'(disp_q), 32'(exp_disp));
      chk(bright_o == exp_disp[23], "R9", "bright_o", 32'(bright_o), 32'(exp_disp[23]));
   endtask

   initial begin : watchdog
      #3_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      int b0;
      logic [23:0] pat;
      logic [29:0] stream;
      tick(3); rst_n = 1'b1; tick(2);

      // R12 reset state
      check_regs("R12");
      chk(sdout == 1'b0, "R12", "sdout", 32'(sdout), 0);
      chk(blank_o == 1'b0, "R12", "blank_o", 32'(blank_o), 0);

      // R1 R2 R3 R8 R9 sweep every configuration value, then a display write
      for (int v = 0; v < 256; v++) begin
         b0 = blank_cnt;
         xfer(64'(v), 8);
         exp_cfg = 8'(v);
         if (!exp_cfg[0]) exp_disp = '0;
         check_regs(exp_cfg[0] ? "R2" : "R8");
         chk(blank_cnt == b0 + 1, "R7", "blank count", 32'(blank_cnt - b0), 1);
         pat = {8'(v), ~8'(v), 8'(v) ^ 8'h5a};
         xfer(64'(pat), 24);
         exp_disp = pat;
         check_regs("R3");
      end

      // R11 dropped lengths, plus saturation past 31 (40 would alias to 8)
      for (int n = 0; n <= 40; n++) begin
         if (n == 8 || n == 24) continue;
         b0 = blank_cnt;
         xfer(64'h00A5_3C96_0F0F_F0F0 ^ 64'(n), n);
         check_regs("R11");
         chk(blank_cnt == b0 + 1, "R7", "blank on dropped", 32'(blank_cnt - b0), 1);
      end

      // R4 registers hold mid-transfer
      pat = 24'h13_57_9B;
      sel_n = 1'b0; tick(2);
      for (int i = 0; i < 24; i++) begin
         clk_bit(pat[23-i]);
         if (i == 7 || i == 15) check_regs("R4");
      end
      sel_n = 1'b1; tick(3);
      exp_disp = pat;
      check_regs("R4");

      // R5 serial clock ignored while deselected
      for (int i = 0; i < 8; i++) clk_bit(1'b1);
      chk(sdout == 1'b0, "R5", "sdout idle", 32'(sdout), 0);
      check_regs("R5");
      b0 = blank_cnt;
      xfer(64'h0, 0);
      check_regs("R5");

      // R6 serial output 24.5 stages behind
      stream = 30'h2B5C_61E7;
      sel_n = 1'b0; tick(2);
      for (int k = 0; k < 30; k++) begin
         clk_bit(stream[29-k]);
         chk(sdout == ((k >= 23) ? stream[29-(k-23)] : 1'b0), "R6", "sdout",
             32'(sdout), 32'((k >= 23) ? stream[29-(k-23)] : 1'b0));
      end
      sel_n = 1'b1; tick(3);
      chk(sdout == 1'b0, "R5", "sdout after release", 32'(sdout), 0);
      check_regs("R11");

      // R10 select falls while serial clock high
      sclk = 1'b1; tick(2);
      sel_n = 1'b0; tick(2);
      sclk = 1'b0; tick(2);
      for (int i = 0; i < 8; i++) clk_bit(i[0]);
      sel_n = 1'b1; tick(3);
      check_regs("R10");
      xfer(64'hC3, 8); exp_cfg = 8'hC3; check_regs("R10");

      // R10 select rises while serial clock high
      b0 = blank_cnt;
      sel_n = 1'b0; tick(2);
      for (int i = 0; i < 8; i++) clk_bit(1'b1);
      sclk = 1'b1; tick(2);
      sel_n = 1'b1; tick(2);
      sclk = 1'b0; tick(3);
      check_regs("R10");
      chk(blank_cnt == b0 + 1, "R7", "blank on desync", 32'(blank_cnt - b0), 1);
      xfer(64'h81, 8); exp_cfg = 8'h81; check_regs("R10");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule